// File: doc/BRIEF.md
# Direct-Mapped Instruction Address Translator

This block translates instruction-fetch addresses in front of an instruction cache. Each cycle it takes a 64-bit effective address with two mode flags: translation on or off, and privileged or unprivileged. Within the same cycle it returns a 56-bit real address, a flag saying whether the translation is valid, a privilege-fault flag and an overall access-permitted flag. It also combines the cache's hit signal with the access result to give a fetch stall.

The entries live in a 64-slot direct-mapped store with 4 KiB pages. The slot is chosen by XOR-folding three 6-bit fields of the page number. A maintenance port writes entries and invalidates them. An invalidate names either one slot, through the hash of its address, or the whole store. A registered, sticky fetch-failed flag records that a presented request was refused. It stays set until a flush or an entry load clears it. Page-table walking, the cache arrays and interrupt generation are handled elsewhere.

The reset `rst_n` is asynchronous and active low. It must be released synchronously to `clk` by the surrounding reset logic.

Top module: `itlb_xlate`

## Requirements
- R1: The slot index of an address is bits 17..12 XOR bits 23..18 XOR bits 29..24. A load (`mnt_load`=1, `mnt_inval`=0) writes valid=1, tag = `mnt_addr[63:18]` and PTE = `mnt_pte` into the slot indexed by `mnt_addr`.
- R2: With `xlate_en`=1, `xlate_ok` is 1 exactly when the indexed slot is valid and its tag equals `ea[63:18]`. On a hit, `real_addr` is the stored PTE bits 55..12 followed by `ea[11:0]`.
- R3: With `xlate_en`=0, `real_addr` equals `ea[55:0]` and `xlate_ok` is 1.
- R4: `priv_fault` is 1 when the privilege bit is set and `priv_mode`=0. The privilege bit is PTE bit 3 of the indexed slot when translation is on, and is taken as 1 when translation is off.
- R5: `access_ok` equals `xlate_ok` AND NOT `priv_fault`.
- R6: A single invalidate (`mnt_inval`=1 with `mnt_addr[11:10]`=00) clears the valid bit of the slot indexed by `mnt_addr`. It does not compare tags, so an entry loaded through a different address that has the same index is removed.
- R7: An invalidate with `mnt_addr[11:10]` nonzero clears every valid bit. Asserting reset also clears every valid bit.
- R8: Maintenance priority is invalidate-all first, then single invalidate, then load. A load presented together with any invalidate is not written.
- R9: `fetch_failed` is 0 after reset. It becomes 1 after a clock edge at which `req`=1 and `access_ok`=0, and it holds its value otherwise.
- R10: A clock edge with `flush`=1 or `mnt_load`=1 clears `fetch_failed`. The clear takes precedence over setting the flag.
- R11: `stall` is 1 unless both `cache_hit` and `access_ok` are 1.
- R12: Maintenance takes effect at the clock edge. A lookup in the same cycle sees the old contents, and the new contents are visible from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Fetch request presented |
| ea | input | 64 | Effective fetch address |
| xlate_en | input | 1 | Translation enable |
| priv_mode | input | 1 | Fetch is privileged |
| cache_hit | input | 1 | Downstream cache reports a hit |
| flush | input | 1 | Pipeline flush, clears the failure flag |
| mnt_load | input | 1 | Load an entry |
| mnt_inval | input | 1 | Invalidate one slot or all slots |
| mnt_addr | input | 64 | Maintenance effective address |
| mnt_pte | input | 64 | PTE to store on a load |
| real_addr | output | 56 | Translated real address |
| xlate_ok | output | 1 | Translation valid |
| priv_fault | output | 1 | Privilege violation |
| access_ok | output | 1 | Fetch permitted |
| fetch_failed | output | 1 | Sticky refused-fetch flag |
| stall | output | 1 | Hold the fetch stage |

## Verification
The properties assume that `rst_n` is released synchronously. They also assume that every input is stable around the rising edge, so that the same-cycle lookup and the next-cycle visibility rules are well defined. The stimulus meets these assumptions by changing inputs only on the falling edge. It draws addresses from a small pool of pages together with aliases that share a slot index but carry a different tag, so that hits, misses and tagless invalidation all occur often. The PTE privilege bit is checked only for slots that have been written at least once, because the stored payload is not reset.

// File: rtl/itlb_pkg.sv
package itlb_pkg;

  // Resolved maintenance action after priority
  typedef enum logic [1:0] {
    MNT_NONE    = 2'd0,
    MNT_LOAD    = 2'd1,
    MNT_INV_ONE = 2'd2,
    MNT_INV_ALL = 2'd3
  } mnt_op_e;

endpackage

// File: rtl/itlb_hash.sv
// XOR-folds FOLDS consecutive IDX_BITS-wide fields above the page offset.
module itlb_hash #(
  parameter int EA_W     = 64,
  parameter int PG_BITS  = 12,
  parameter int IDX_BITS = 6,
  parameter int FOLDS    = 3
) (
  input  logic [EA_W-1:0]     addr,
  output logic [IDX_BITS-1:0] idx
);

  localparam int TOP = PG_BITS + FOLDS * IDX_BITS;

  logic [IDX_BITS-1:0] part [FOLDS];

  generate
    for (genvar f = 0; f < FOLDS; f++) begin : g_field
      assign part[f] = addr[PG_BITS + f*IDX_BITS +: IDX_BITS];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int f = 0; f < FOLDS; f++) begin
      idx = idx ^ part[f];
    end
  end

  logic unused_hash_hi;
  logic unused_hash_lo;
  generate
    if (TOP < EA_W) begin : g_hi
      assign unused_hash_hi = ^addr[EA_W-1:TOP];
    end else begin : g_nohi
      assign unused_hash_hi = 1'b0;
    end
  endgenerate
  assign unused_hash_lo = ^addr[PG_BITS-1:0];

endmodule

// File: rtl/itlb_array.sv
// Valid bits (reset) plus tag and PTE payload (not reset).
module itlb_array
  import itlb_pkg::*;
#(
  parameter int IDX_BITS = 6,
  parameter int TAG_W    = 46,
  parameter int PTE_W    = 64
) (
  input  logic                clk,
  input  logic                rst_n,
  input  mnt_op_e             op,
  input  logic [IDX_BITS-1:0] wr_idx,
  input  logic [TAG_W-1:0]    wr_tag,
  input  logic [PTE_W-1:0]    wr_pte,
  input  logic [IDX_BITS-1:0] rd_idx,
  output logic                rd_valid,
  output logic [TAG_W-1:0]    rd_tag,
  output logic [PTE_W-1:0]    rd_pte
);

  localparam int DEPTH = 1 << IDX_BITS;

  logic [DEPTH-1:0] valid_q, valid_d;
  logic [TAG_W-1:0] tag_q [DEPTH];
  logic [PTE_W-1:0] pte_q [DEPTH];
  logic             wr_en;

  assign wr_en = (op == MNT_LOAD);

  always_comb begin
    valid_d = valid_q;
    case (op)
      MNT_INV_ALL: valid_d = '0;
      MNT_INV_ONE: valid_d[wr_idx] = 1'b0;
      MNT_LOAD:    valid_d[wr_idx] = 1'b1;
      default:     valid_d = valid_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= '0;
    end else begin
      valid_q <= valid_d;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[wr_idx] <= wr_tag;
      pte_q[wr_idx] <= wr_pte;
    end
  end

  assign rd_valid = valid_q[rd_idx];
  assign rd_tag   = tag_q[rd_idx];
  assign rd_pte   = pte_q[rd_idx];

endmodule

// File: rtl/itlb_lookup.sv
// Combinational hit test, address formation and permission check.
module itlb_lookup #(
  parameter int EA_W     = 64,
  parameter int RA_W     = 56,
  parameter int PG_BITS  = 12,
  parameter int TAG_W    = 46,
  parameter int PTE_W    = 64,
  parameter int PRIV_BIT = 3
) (
  input  logic [EA_W-1:0]  ea,
  input  logic             xlate_en,
  input  logic             priv_mode,
  input  logic             rd_valid,
  input  logic [TAG_W-1:0] rd_tag,
  input  logic [PTE_W-1:0] rd_pte,
  output logic [RA_W-1:0]  real_addr,
  output logic             xlate_ok,
  output logic             priv_fault,
  output logic             access_ok
);

  logic tag_match;
  logic priv_bit;

  assign tag_match = (rd_tag == ea[EA_W-1 -: TAG_W]);

  always_comb begin
    if (xlate_en) begin
      real_addr = {rd_pte[RA_W-1:PG_BITS], ea[PG_BITS-1:0]};
      xlate_ok  = rd_valid && tag_match;
      priv_bit  = rd_pte[PRIV_BIT];
    end else begin
      real_addr = ea[RA_W-1:0];
      xlate_ok  = 1'b1;
      priv_bit  = 1'b1;
    end
    priv_fault = priv_bit && !priv_mode;
    access_ok  = xlate_ok && !priv_fault;
  end

  logic unused_pte;
  assign unused_pte = ^rd_pte;

endmodule

// File: rtl/itlb_failflag.sv
// Sticky refused-fetch indication.
module itlb_failflag (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  input  logic access_ok,
  input  logic flush,
  input  logic load_req,
  output logic fetch_failed
);

  logic ff_q, ff_d;

  always_comb begin
    ff_d = ff_q;
    if (flush || load_req) begin
      ff_d = 1'b0;
    end else if (req && !access_ok) begin
      ff_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ff_q <= 1'b0;
    end else begin
      ff_q <= ff_d;
    end
  end

  assign fetch_failed = ff_q;

endmodule

// File: rtl/itlb_xlate.sv
module itlb_xlate
  import itlb_pkg::*;
#(
  parameter int EA_W     = 64,
  parameter int RA_W     = 56,
  parameter int PG_BITS  = 12,
  parameter int IDX_BITS = 6,
  parameter int FOLDS    = 3,
  parameter int PTE_W    = 64,
  parameter int PRIV_BIT = 3,
  parameter int ALL_LO   = 10,
  parameter int ALL_HI   = 11
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req,
  input  logic [EA_W-1:0] ea,
  input  logic            xlate_en,
  input  logic            priv_mode,
  input  logic            cache_hit,
  input  logic            flush,
  input  logic            mnt_load,
  input  logic            mnt_inval,
  input  logic [EA_W-1:0] mnt_addr,
  input  logic [63:0]     mnt_pte,
  output logic [RA_W-1:0] real_addr,
  output logic            xlate_ok,
  output logic            priv_fault,
  output logic            access_ok,
  output logic            fetch_failed,
  output logic            stall
);

  localparam int TAG_W = EA_W - PG_BITS - IDX_BITS;

  logic [IDX_BITS-1:0] rd_idx, wr_idx;
  logic                rd_valid;
  logic [TAG_W-1:0]    rd_tag;
  logic [PTE_W-1:0]    rd_pte;
  mnt_op_e             op;

  itlb_hash #(.EA_W(EA_W), .PG_BITS(PG_BITS), .IDX_BITS(IDX_BITS), .FOLDS(FOLDS))
    u_hash_rd (.addr(ea), .idx(rd_idx));

  itlb_hash #(.EA_W(EA_W), .PG_BITS(PG_BITS), .IDX_BITS(IDX_BITS), .FOLDS(FOLDS))
    u_hash_wr (.addr(mnt_addr), .idx(wr_idx));

  always_comb begin
    if (mnt_inval && (|mnt_addr[ALL_HI:ALL_LO])) begin
      op = MNT_INV_ALL;
    end else if (mnt_inval) begin
      op = MNT_INV_ONE;
    end else if (mnt_load) begin
      op = MNT_LOAD;
    end else begin
      op = MNT_NONE;
    end
  end

  itlb_array #(.IDX_BITS(IDX_BITS), .TAG_W(TAG_W), .PTE_W(PTE_W)) u_array (
    .clk      (clk),
    .rst_n    (rst_n),
    .op       (op),
    .wr_idx   (wr_idx),
    .wr_tag   (mnt_addr[EA_W-1 -: TAG_W]),
    .wr_pte   (mnt_pte[PTE_W-1:0]),
    .rd_idx   (rd_idx),
    .rd_valid (rd_valid),
    .rd_tag   (rd_tag),
    .rd_pte   (rd_pte)
  );

  itlb_lookup #(
    .EA_W(EA_W), .RA_W(RA_W), .PG_BITS(PG_BITS), .TAG_W(TAG_W),
    .PTE_W(PTE_W), .PRIV_BIT(PRIV_BIT)
  ) u_lookup (
    .ea         (ea),
    .xlate_en   (xlate_en),
    .priv_mode  (priv_mode),
    .rd_valid   (rd_valid),
    .rd_tag     (rd_tag),
    .rd_pte     (rd_pte),
    .real_addr  (real_addr),
    .xlate_ok   (xlate_ok),
    .priv_fault (priv_fault),
    .access_ok  (access_ok)
  );

  itlb_failflag u_fail (
    .clk          (clk),
    .rst_n        (rst_n),
    .req          (req),
    .access_ok    (access_ok),
    .flush        (flush),
    .load_req     (mnt_load),
    .fetch_failed (fetch_failed)
  );

  assign stall = !(cache_hit && access_ok);

  logic unused_mnt;
  assign unused_mnt = ^mnt_addr[ALL_LO-1:0] ^ ^mnt_pte;

endmodule

// File: rtl/itlb_xlate_chk.sv
module itlb_xlate_chk #(
  parameter int EA_W = 64,
  parameter int RA_W = 56
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req,
  input logic [EA_W-1:0] ea,
  input logic            xlate_en,
  input logic            priv_mode,
  input logic            cache_hit,
  input logic            flush,
  input logic            mnt_load,
  input logic            mnt_inval,
  input logic [EA_W-1:0] mnt_addr,
  input logic [RA_W-1:0] real_addr,
  input logic            xlate_ok,
  input logic            priv_fault,
  input logic            access_ok,
  input logic            fetch_failed,
  input logic            stall
);

  function automatic logic [5:0] slot_of(input logic [EA_W-1:0] a);
    return a[17:12] ^ a[23:18] ^ a[29:24];
  endfunction

  assert_passthru_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !xlate_en |-> (xlate_ok && real_addr == ea[RA_W-1:0]));

  assert_priv_needs_user_R4: assert property (@(posedge clk) disable iff (!rst_n)
    priv_fault |-> !priv_mode);

  assert_access_R5: assert property (@(posedge clk) disable iff (!rst_n)
    access_ok |-> (xlate_ok && !priv_fault));

  assert_load_visible_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_load && !mnt_inval) |=> (!xlate_en || ea != $past(mnt_addr) || xlate_ok));

  assert_inv_one_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_inval && !mnt_load) |=>
      (!xlate_en || slot_of(ea) != $past(slot_of(mnt_addr)) || !xlate_ok));

  assert_inv_all_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mnt_inval && mnt_addr[11:10] != 2'b00) |=> (!xlate_en || !xlate_ok));

  assert_fail_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !access_ok && !flush && !mnt_load) |=> fetch_failed);

  assert_fail_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_failed && !flush && !mnt_load) |=> fetch_failed);

  assert_fail_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (flush || mnt_load) |=> !fetch_failed);

  assert_stall_deny_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!access_ok || !cache_hit) |-> stall);

endmodule

bind itlb_xlate itlb_xlate_chk #(.EA_W(EA_W), .RA_W(RA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req(req), .ea(ea), .xlate_en(xlate_en),
  .priv_mode(priv_mode), .cache_hit(cache_hit), .flush(flush),
  .mnt_load(mnt_load), .mnt_inval(mnt_inval), .mnt_addr(mnt_addr),
  .real_addr(real_addr), .xlate_ok(xlate_ok), .priv_fault(priv_fault),
  .access_ok(access_ok), .fetch_failed(fetch_failed), .stall(stall)
);

// File: tb/itlb_xlate_tb.sv
`timescale 1ns/1ps
module itlb_xlate_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, xlate_en, priv_mode, cache_hit, flush, mnt_load, mnt_inval;
  logic [63:0] ea, mnt_addr, mnt_pte;
  logic [55:0] real_addr;
  logic        xlate_ok, priv_fault, access_ok, fetch_failed, stall;

  always #2.5 clk = ~clk;

  itlb_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .ea(ea), .xlate_en(xlate_en),
    .priv_mode(priv_mode), .cache_hit(cache_hit), .flush(flush),
    .mnt_load(mnt_load), .mnt_inval(mnt_inval), .mnt_addr(mnt_addr),
    .mnt_pte(mnt_pte), .real_addr(real_addr), .xlate_ok(xlate_ok),
    .priv_fault(priv_fault), .access_ok(access_ok),
    .fetch_failed(fetch_failed), .stall(stall)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // reference model
  bit          mv [64];
  bit          mw [64];
  logic [45:0] mt [64];
  logic [63:0] mp [64];
  bit          mff;

  // stimulus for the next cycle
  bit          t_req, t_xen, t_pm, t_hit, t_fl, t_ld, t_inv;
  logic [63:0] t_ea, t_maddr, t_mpte;

  function automatic logic [5:0] hsh(input logic [63:0] a);
    return a[17:12] ^ a[23:18] ^ a[29:24];
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 64; i++) mv[i] = 1'b0;
    mff = 1'b0;
  endtask

  task automatic idle_inputs();
    t_req = 0; t_xen = 0; t_pm = 1; t_hit = 0; t_fl = 0; t_ld = 0; t_inv = 0;
    t_ea = '0; t_maddr = '0; t_mpte = '0;
  endtask

  // apply stimulus, compare combinational outputs, then advance the model
  task automatic go(input string tag);
    logic [5:0]  idx;
    bit          e_ok, e_pb, e_pf, e_acc, known;
    logic [55:0] e_ra;
    @(negedge clk);
    req = t_req; ea = t_ea; xlate_en = t_xen; priv_mode = t_pm;
    cache_hit = t_hit; flush = t_fl; mnt_load = t_ld; mnt_inval = t_inv;
    mnt_addr = t_maddr; mnt_pte = t_mpte;
    #1;
    idx = hsh(t_ea);
    if (t_xen) begin
      e_ok  = mv[idx] && (mt[idx] == t_ea[63:18]);
      e_ra  = {mp[idx][55:12], t_ea[11:0]};
      e_pb  = mp[idx][3];
      known = mw[idx];
    end else begin
      e_ok = 1'b1; e_ra = t_ea[55:0]; e_pb = 1'b1; known = 1'b1;
    end
    e_pf  = e_pb && !t_pm;
    e_acc = e_ok && !e_pf;
    chk(tag, "xlate_ok", {63'd0, xlate_ok}, {63'd0, e_ok});
    if (e_ok) chk(tag, "real_addr", {8'd0, real_addr}, {8'd0, e_ra});
    if (known) chk(tag, "priv_fault", {63'd0, priv_fault}, {63'd0, e_pf});
    chk(tag, "access_ok", {63'd0, access_ok}, {63'd0, e_acc});
    chk(tag, "stall", {63'd0, stall}, {63'd0, !(t_hit && e_acc)});
    chk(tag, "fetch_failed", {63'd0, fetch_failed}, {63'd0, mff});
    @(posedge clk);
    if (t_inv && t_maddr[11:10] != 2'b00) begin
      for (int i = 0; i < 64; i++) mv[i] = 1'b0;
    end else if (t_inv) begin
      mv[hsh(t_maddr)] = 1'b0;
    end else if (t_ld) begin
      mv[hsh(t_maddr)] = 1'b1;
      mw[hsh(t_maddr)] = 1'b1;
      mt[hsh(t_maddr)] = t_maddr[63:18];
      mp[hsh(t_maddr)] = t_mpte;
    end
    if (t_fl || t_ld) mff = 1'b0;
    else if (t_req && !e_acc) mff = 1'b1;
  endtask

  task automatic do_reset(input string tag);
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    #1;
    chk(tag, "fetch_failed in reset", {63'd0, fetch_failed}, 64'd0);
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  logic [63:0] pool [8];
  logic [63:0] pa, pb, pc, alias_b;
  logic [63:0] pte_a, pte_b;

  initial begin
    #500us;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    void'($urandom(32'd1357));
    for (int i = 0; i < 64; i++) begin mv[i] = 0; mw[i] = 0; mt[i] = '0; mp[i] = '0; end
    mff = 0;
    idle_inputs();
    req = 0; ea = '0; xlate_en = 0; priv_mode = 1; cache_hit = 0; flush = 0;
    mnt_load = 0; mnt_inval = 0; mnt_addr = '0; mnt_pte = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    chk("R9", "fetch_failed after reset", {63'd0, fetch_failed}, 64'd0);
    chk("R11", "stall with no cache hit", {63'd0, stall}, 64'd1);
    @(negedge clk);
    rst_n = 1'b1;

    pa      = 64'hABCD_1234_5678_9ABC & ~64'hC00;
    pc      = 64'h1357_9BDF_0246_8000;
    alias_b = pa ^ (64'h3F << 18) ^ (64'h3F << 24);  // same slot, other tag
    pte_a   = 64'h00F0_0000_1234_5000;
    pte_b   = 64'h0012_3456_789A_B008;               // privilege bit set

    // translation off, unprivileged faults, privileged passes
    idle_inputs(); t_ea = pa; t_req = 1; t_pm = 1; t_hit = 1; go("R3");
    t_pm = 0; go("R4");
    t_fl = 1; t_pm = 1; go("R10");
    // empty store misses
    idle_inputs(); t_xen = 1; t_ea = pa; go("R2");
    // load A while looking A up: old contents this cycle
    t_ld = 1; t_maddr = pa; t_mpte = pte_a; go("R12");
    idle_inputs(); t_xen = 1; t_ea = pa; t_hit = 1; go("R1");
    t_ea = pa ^ 64'hFFF; go("R2");
    // alias shares the slot but not the tag
    t_ea = alias_b; go("R2");
    // invalidate through the alias: A vanishes
    idle_inputs(); t_inv = 1; t_maddr = alias_b; t_xen = 1; t_ea = pa; go("R12");
    idle_inputs(); t_xen = 1; t_ea = pa; go("R6");
    // invalidate-all via mode bits
    idle_inputs(); t_ld = 1; t_maddr = pa; t_mpte = pte_a; go("R1");
    idle_inputs(); t_ld = 1; t_maddr = pc; t_mpte = pte_b; go("R1");
    idle_inputs(); t_inv = 1; t_maddr = 64'h400; go("R7");
    idle_inputs(); t_xen = 1; t_ea = pa; go("R7");
    t_ea = pc; go("R7");
    // priority: load lost to single invalidate and to invalidate-all
    idle_inputs(); t_ld = 1; t_inv = 1; t_maddr = pa; t_mpte = pte_a; go("R8");
    idle_inputs(); t_xen = 1; t_ea = pa; go("R8");
    idle_inputs(); t_ld = 1; t_inv = 1; t_maddr = pa | 64'h800; t_mpte = pte_a; go("R8");
    idle_inputs(); t_xen = 1; t_ea = pa; go("R8");
    // privilege bit in the PTE
    idle_inputs(); t_ld = 1; t_maddr = pc; t_mpte = pte_b; go("R1");
    idle_inputs(); t_xen = 1; t_ea = pc; t_pm = 0; t_hit = 1; go("R4");
    t_pm = 1; go("R5");
    // sticky failure flag
    idle_inputs(); t_req = 1; t_xen = 1; t_ea = pa; go("R9");
    idle_inputs(); go("R9");
    go("R9");
    t_fl = 1; go("R10");
    idle_inputs(); go("R10");
    t_req = 1; t_xen = 1; t_ea = pa; go("R9");
    idle_inputs(); t_ld = 1; t_maddr = pa; t_mpte = pte_a; go("R10");
    idle_inputs(); go("R10");
    t_req = 1; t_xen = 1; t_ea = alias_b; t_fl = 1; go("R10");
    idle_inputs(); go("R10");
    // mid-run reset empties the store
    do_reset("R7");
    idle_inputs(); t_xen = 1; t_ea = pa; go("R7");

    // constrained random
    for (int i = 0; i < 8; i++) pool[i] = {$urandom, $urandom};
    for (int n = 0; n < 4000; n++) begin
      logic [63:0] base;
      base = pool[$urandom % 8];
      if ($urandom % 4 == 0) base = base ^ (64'(($urandom % 63) + 1) * 64'h0104_0000);
      t_ea    = (base & ~64'hFFF) | 64'($urandom % 4096);
      t_req   = ($urandom % 4) != 0;
      t_xen   = ($urandom % 4) != 0;
      t_pm    = ($urandom % 2) != 0;
      t_hit   = ($urandom % 2) != 0;
      t_fl    = ($urandom % 10) == 0;
      t_ld    = ($urandom % 4) == 0;
      t_inv   = ($urandom % 8) == 0;
      pb      = pool[$urandom % 8];
      t_maddr = (pb & ~64'hFFF) | 64'(($urandom % 16 == 0) ? 12'h400 : 12'h000);
      t_mpte  = {$urandom, $urandom};
      go("R2");
    end
    summary();
  end

endmodule